// File: doc/BRIEF.md
# Converter Result FIFO with Status

This block buffers measurement words coming out of a converter's receive logic until software collects them. The converter side presents a one-cycle write strobe with a result word. The software side pops the oldest result by strobing a data-register read. During the strobe cycle the read data output shows the head entry, and the pop takes effect at the clock edge. The buffer holds sixteen results. It also keeps a separate occupancy count, so that equal write and read indices can still be read as either full or empty.

A read-only 32-bit status word shows the raw write and read indices, the full and empty flags, a sticky overrun flag and an at-or-above-watermark flag. The watermark level is a programmable input. A result that arrives while every entry is occupied is thrown away, and it sets the overrun flag. The interrupt output follows that flag until a one-cycle clear strobe removes it.

Top module: `conv_result_fifo`

## Requirements
- R1: The buffer holds 16 results, returned in arrival order. The write index sits in status bits 11:8 and the read index in bits 7:4. Both are 4-bit values that wrap from 15 to 0.
- R2: Status bit 3 is full (16 stored), bit 2 is empty (0 stored), bit 1 is overrun and bit 0 is watermark. Bits 31:12 always read 0.
- R3: After synchronous reset both indices are 0 and the full and overrun flags are 0. The empty flag is 1 and `irq` is 0. With a watermark level of 1 or more, the watermark flag is 0, so the status word reads 0x00000004.
- R4: A write while not full stores `wr_data` at the write index. The write index then advances by one at the clock edge.
- R5: While `rd_en` is high and the buffer is not empty, `rd_data` shows the oldest entry in that same cycle. The read index advances by one at the clock edge.
- R6: A write while full, without an accepted read in the same cycle, is discarded. The write index and the stored data do not change, and the overrun flag becomes 1. This repeats for every such arrival.
- R7: `irq` is 1 exactly when the overrun flag is 1.
- R8: The overrun flag stays set until a cycle with `ovr_clr` high. If a discarded arrival falls in that same cycle, the flag stays set.
- R9: A read while empty drives `rd_data` to 0 and leaves the read index unchanged.
- R10: The watermark flag is 1 when the stored count is at or above `wm_level` (0 to 16), and 0 otherwise.
- R11: A write and a read in the same cycle while full are both accepted. The count stays 16 and no overrun is flagged.
- R12: A write and a read in the same cycle while empty store the write, ignore the read and drive `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Result arrival strobe |
| wr_data | input | 16 | Arriving result word |
| rd_en | input | 1 | Data-register read strobe (pop) |
| rd_data | output | 16 | Head result, 0 when empty |
| wm_level | input | 5 | Watermark level, 0 to 16 |
| ovr_clr | input | 1 | One-cycle overrun clear |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request, follows overrun |

## Verification
A write index that drifts from the read index shows up in the very next status word. It also appears as a wrong result at the next pop, because the data no longer comes back in arrival order. An occupancy count that is off by one flips the full, empty or watermark bits in the cycle after the faulty update. It also turns a legal write into a false overrun, or lets a write overwrite unread data. A lost or stuck overrun flag shows on `irq` one edge after the dropped arrival or the clear.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

    localparam int RES_W  = 16;
    localparam int IDX_W  = 4;
    localparam int SLOTS  = 1 << IDX_W;
    localparam int CNT_W  = IDX_W + 1;
    localparam int STAT_W = 32;
    localparam int PAD_W  = STAT_W - 2 * IDX_W - 4;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [RES_W-1:0] res_t;

    typedef struct packed {
        logic [PAD_W-1:0] pad;
        idx_t             wr_idx;
        idx_t             rd_idx;
        logic             is_full;
        logic             is_empty;
        logic             overrun;
        logic             at_mark;
    } stat_word_t;

    typedef struct packed {
        logic take_wr;
        logic take_rd;
        logic drop_wr;
    } xfer_t;

    localparam cnt_t FULL_CNT = cnt_t'(SLOTS);

    function automatic idx_t idx_step(input idx_t v);
        return idx_t'(v + idx_t'(1));
    endfunction

    function automatic xfer_t decide(input logic wr, input logic rd, input cnt_t cnt);
        xfer_t x;
        x.take_rd = rd && (cnt != '0);
        x.take_wr = wr && ((cnt != FULL_CNT) || x.take_rd);
        x.drop_wr = wr && !x.take_wr;
        return x;
    endfunction

endpackage

// File: rtl/rfifo_store.sv
module rfifo_store
    import rfifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  idx_t waddr,
    input  res_t wdata,
    input  idx_t raddr,
    input  logic hide,
    output res_t rdata
);
    res_t cells [SLOTS];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    cells[g] <= '0;
                end else if (we && (waddr == idx_t'(g))) begin
                    cells[g] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = hide ? '0 : cells[raddr];

endmodule

// File: rtl/rfifo_ctrl.sv
module rfifo_ctrl
    import rfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  rd_en,
    input  logic  ovr_clr,
    output xfer_t xfer,
    output idx_t  wr_idx,
    output idx_t  rd_idx,
    output cnt_t  fill,
    output logic  ovr
);
    assign xfer = decide(wr_en, rd_en, fill);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            rd_idx <= '0;
            fill   <= '0;
            ovr    <= 1'b0;
        end else begin
            if (xfer.take_wr) wr_idx <= idx_step(wr_idx);
            if (xfer.take_rd) rd_idx <= idx_step(rd_idx);
            case ({xfer.take_wr, xfer.take_rd})
                2'b10:   fill <= cnt_t'(fill + cnt_t'(1));
                2'b01:   fill <= cnt_t'(fill - cnt_t'(1));
                default: fill <= fill;
            endcase
            if (xfer.drop_wr)  ovr <= 1'b1;
            else if (ovr_clr)  ovr <= 1'b0;
        end
    end

    AST_IDX_GAP: assert property (@(posedge clk) disable iff (rst)
        idx_t'(wr_idx - rd_idx) == fill[IDX_W-1:0]);                               // R1
    AST_FILL_RANGE: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL_CNT);                                                         // R1
    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        rd_en && (fill != '0) |=> rd_idx == idx_step($past(rd_idx)));             // R5
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_en && !rd_en && (fill == FULL_CNT) |=> $stable(wr_idx) && ovr);        // R6
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst)
        ovr_clr && !(wr_en && !rd_en && (fill == FULL_CNT)) |=> !ovr);            // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        rd_en && (fill == '0) |=> $stable(rd_idx));                               // R9
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        wr_en && rd_en && (fill == FULL_CNT) && !ovr |=> !ovr && fill == FULL_CNT); // R11

endmodule

// File: rtl/rfifo_status.sv
module rfifo_status
    import rfifo_pkg::*;
(
    input  idx_t       wr_idx,
    input  idx_t       rd_idx,
    input  cnt_t       fill,
    input  logic       ovr,
    input  cnt_t       mark,
    output stat_word_t word
);
    always_comb begin
        word          = '0;
        word.wr_idx   = wr_idx;
        word.rd_idx   = rd_idx;
        word.is_full  = (fill == FULL_CNT);
        word.is_empty = (fill == '0);
        word.overrun  = ovr;
        word.at_mark  = (fill >= mark);
    end

endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
    import rfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RES_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [RES_W-1:0]  rd_data,
    input  logic [CNT_W-1:0]  wm_level,
    input  logic              ovr_clr,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    xfer_t      xfer;
    idx_t       wr_idx;
    idx_t       rd_idx;
    cnt_t       fill;
    logic       ovr;
    stat_word_t word;

    rfifo_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .ovr_clr (ovr_clr),
        .xfer    (xfer),
        .wr_idx  (wr_idx),
        .rd_idx  (rd_idx),
        .fill    (fill),
        .ovr     (ovr)
    );

    rfifo_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (xfer.take_wr),
        .waddr (wr_idx),
        .wdata (wr_data),
        .raddr (rd_idx),
        .hide  (!xfer.take_rd),
        .rdata (rd_data)
    );

    rfifo_status u_stat (
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .fill   (fill),
        .ovr    (ovr),
        .mark   (wm_level),
        .word   (word)
    );

    assign status = word;
    assign irq    = ovr;

    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        irq == status[1]);                                                         // R7
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[31:12] == '0);                                                      // R2
    AST_EMPTY_DATA: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> rd_data == '0);                                              // R9

endmodule

// File: tb/conv_result_fifo_test.sv
module conv_result_fifo_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic        rd_en;
    logic [15:0] rd_data;
    logic [4:0]  wm_level;
    logic        ovr_clr;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] m_mem [16];
    int m_wp, m_rp, m_cnt;
    bit m_ovr;

    always #5 clk = ~clk;

    conv_result_fifo uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .wm_level(wm_level),
        .ovr_clr(ovr_clr), .status(status), .irq(irq)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s;
        s = '0;
        s[11:8] = 4'(m_wp);
        s[7:4]  = 4'(m_rp);
        s[3]    = (m_cnt == 16);
        s[2]    = (m_cnt == 0);
        s[1]    = m_ovr;
        s[0]    = (m_cnt >= int'(wm_level));
        return s;
    endfunction

    // One clock: drive at negedge, check read data before the edge, status after it.
    task automatic step(input string tag, input bit wr, input logic [15:0] d,
                        input bit rd, input bit clr);
        bit rok, wok, drop;
        wr_en = wr; wr_data = d; rd_en = rd; ovr_clr = clr;
        rok  = rd && (m_cnt != 0);
        wok  = wr && ((m_cnt != 16) || rok);
        drop = wr && !wok;
        #1;
        if (rd) check32({tag, " rd_data"}, {16'h0, rd_data},
                        {16'h0, rok ? m_mem[m_rp] : 16'h0});
        @(posedge clk);
        if (wok) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % 16; end
        if (rok) m_rp = (m_rp + 1) % 16;
        m_cnt = m_cnt + (wok ? 1 : 0) - (rok ? 1 : 0);
        if (drop) m_ovr = 1;
        else if (clr) m_ovr = 0;
        @(negedge clk);
        wr_en = 0; rd_en = 0; ovr_clr = 0;
        check32({tag, " status"}, status, exp_status());
        check32({tag, " irq R7"}, {31'h0, irq}, {31'h0, m_ovr});
    endtask

    // R3 R2: reset state
    task automatic t_reset();
        rst = 1; wr_en = 0; rd_en = 0; ovr_clr = 0; wr_data = 0; wm_level = 5'd4;
        repeat (3) @(negedge clk);
        rst = 0;
        m_wp = 0; m_rp = 0; m_cnt = 0; m_ovr = 0;
        @(negedge clk);
        check32("R3 reset status", status, 32'h0000_0004);
        check32("R3 reset irq", {31'h0, irq}, 32'h0);
    endtask

    // R4 R5 R10 R1: fill past the watermark, then drain in order
    task automatic t_fill_drain(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) step("R4 R10 write", 1, base + 16'(i * 7), 0, 0);
        for (int i = 0; i < n; i++) step("R5 R1 read", 0, 0, 1, 0);
    endtask

    // R9 R12: reads on an empty buffer
    task automatic t_empty();
        step("R9 empty read", 0, 0, 1, 0);
        step("R9 empty read again", 0, 0, 1, 0);
        step("R12 write+read on empty", 1, 16'hBEEF, 1, 0);
        step("R12 drain", 0, 0, 1, 0);
    endtask

    // R6 R7 R8: overflow, sticky flag, clear racing a drop
    task automatic t_overflow();
        for (int i = 0; i < 16; i++) step("R2 fill full", 1, 16'h1000 + 16'(i), 0, 0);
        for (int i = 0; i < 3; i++) step("R6 drop", 1, 16'hDEAD, 0, 0);
        step("R8 idle sticky", 0, 0, 0, 0);
        step("R8 clear with drop", 1, 16'hDEAD, 0, 1);
        step("R8 clear alone", 0, 0, 0, 1);
        step("R11 swap when full", 1, 16'h2222, 1, 0);
        for (int i = 0; i < 16; i++) step("R6 R1 drain intact", 0, 0, 1, 0);
    endtask

    // R10: extreme watermark levels
    task automatic t_levels();
        wm_level = 5'd0;
        @(negedge clk);
        check32("R10 level 0 on empty", status, exp_status());
        wm_level = 5'd16;
        for (int i = 0; i < 16; i++) step("R10 level 16", 1, 16'(i), 0, 0);
        step("R10 level 16 drop-one", 0, 0, 1, 0);
        for (int i = 0; i < 15; i++) step("R10 drain", 0, 0, 1, 0);
        wm_level = 5'd4;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_fill_drain(5, 16'h0100);
        t_empty();
        t_fill_drain(12, 16'h0A00);
        t_overflow();
        t_levels();
        t_fill_drain(16, 16'h3300);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule